// File: doc/BRIEF.md
# Overload Hiccup Sequencer

This block decides when a supply output must be cut after its overload comparator trips, and keeps the overload status flag that software reads. It has two modes, chosen by a mode input. In hiccup mode, an overload switches the output off for a long rest period. The output then comes back for a short retry period, and this repeats until a retry period passes with no overload at all. In clamp-only mode, the output is never cut: the flag just follows the comparator.

The comparator input is assumed to be synchronised already. Both periods are counted in pulses of a 1 kHz tick input. The defaults are 900 ticks of rest and 20 ticks of retry. Until the soft-start-done input is high, or while the block enable is low, the sequencer stays idle with the flag low. The current clamp itself is outside this block.

Top module: `ocp_sequencer`

## Requirements
- R1: Once reset is released, the flag is low and the sequencer is idle. While soft-start is not done, the output follows the enable input.
- R2: In hiccup mode (`static_mode_i` = 0), an overload sampled while idle sets the flag high and turns the output off on the next clock edge.
- R3: The output stays off for exactly T_OFF tick pulses, counted from the first tick after the output turns off. It turns on again on the edge that takes the T_OFF-th tick.
- R4: Each retry period lasts exactly T_ON tick pulses. If an overload is sampled on any cycle of the retry period, the output turns off again when the period ends, and the flag stays high.
- R5: A retry period with no overload sampled returns the block to idle. The output stays on and the flag clears on the edge that takes the period's last tick.
- R6: In clamp-only mode (`static_mode_i` = 1), the output is never turned off. The flag equals the comparator value sampled on the previous edge.
- R7: Changing from clamp-only to hiccup mode while an overload is present turns the output off on the next edge. Changing from hiccup to clamp-only mode restores the output on the next edge and clears the period timer, so the next rest period again lasts the full T_OFF ticks.
- R8: With `enable_i` low, the output is off. On the next edge the sequencer returns to idle with the flag low.
- R9: While `ss_done_i` is low, overloads are ignored and the flag stays low.
- R10: Time advances only on tick pulses. Without ticks, an off output stays off and the flag stays high for as long as the ticks are absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable; low forces the output off and the sequencer idle |
| ss_done_i | input | 1 | Soft-start done; low holds the sequencer idle |
| static_mode_i | input | 1 | 1 = clamp-only mode, 0 = hiccup mode |
| ovl_i | input | 1 | Synchronised overload comparator |
| tick_i | input | 1 | 1 kHz single-cycle time-base pulse |
| out_on_o | output | 1 | Output enable to the power stage |
| ovl_flag_o | output | 1 | Overload status flag |

## Verification
The sharpest collision is an overload arriving on the same cycle as the tick that closes a retry period. That overload must still send the output back off and must not clear the flag. The bench provokes this with one-cycle overload pulses placed at different phases of the tick. A second collision is a mode change landing while the rest timer is partly run down. The bench switches modes in the middle of an overload and then measures the next rest period in ticks. A behavioural reference model, compared on every clock, judges both collisions, and directed tick counts back it up.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFF   = 2'd1,
    ST_RETRY = 2'd2
  } ocp_state_e;
endpackage

// File: rtl/ocp_win_timer.sv
module ocp_win_timer #(
  parameter int T_OFF = 900,
  parameter int T_ON  = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic sel_off_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int MAXW  = (T_OFF > T_ON) ? T_OFF : T_ON;
  localparam int CNT_W = $clog2(MAXW + 1);
  localparam logic [CNT_W-1:0] LAST_OFF = CNT_W'(T_OFF - 1);
  localparam logic [CNT_W-1:0] LAST_ON  = CNT_W'(T_ON - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last   = sel_off_i ? LAST_OFF : LAST_ON;
  assign done_o = !clr_i && tick_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (tick_i)             cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end

  // R3
  cnt_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> (cnt_q <= last));

  // R10
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ocp_ctrl.sv
module ocp_ctrl
  import ocp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       ss_done_i,
  input  logic       static_i,
  input  logic       ovl_i,
  input  logic       done_i,
  output ocp_state_e state_o,
  output logic       flag_o,
  output logic       clr_o,
  output logic       sel_off_o
);
  ocp_state_e state_q, state_d;
  logic       flag_q, flag_d;
  logic       hit_q, hit_d;
  logic       active;

  assign active = enable_i && ss_done_i;

  always_comb begin
    state_d = state_q;
    flag_d  = flag_q;
    hit_d   = hit_q;
    if (!active) begin
      state_d = ST_IDLE;
      flag_d  = 1'b0;
      hit_d   = 1'b0;
    end else if (static_i) begin
      state_d = ST_IDLE;
      flag_d  = ovl_i;
      hit_d   = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          hit_d = 1'b0;
          if (ovl_i) begin
            state_d = ST_OFF;
            flag_d  = 1'b1;
          end else begin
            flag_d  = 1'b0;
          end
        end
        ST_OFF: begin
          hit_d = 1'b0;
          if (done_i) state_d = ST_RETRY;
        end
        ST_RETRY: begin
          if (done_i) begin
            hit_d = 1'b0;
            if (hit_q || ovl_i) begin
              state_d = ST_OFF;
            end else begin
              state_d = ST_IDLE;
              flag_d  = 1'b0;
            end
          end else begin
            hit_d = hit_q || ovl_i;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      flag_q  <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
      hit_q   <= hit_d;
    end
  end

  assign state_o   = state_q;
  assign flag_o    = flag_q;
  assign clr_o     = !active || static_i || (state_q == ST_IDLE);
  assign sel_off_o = (state_q == ST_OFF);

  // R2
  trip_to_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !static_i && state_q == ST_IDLE && ovl_i) |=> (state_q == ST_OFF && flag_q));

  // R4
  off_implies_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF) |-> flag_q);

  // R5
  clean_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !static_i && state_q == ST_RETRY && done_i && !hit_q && !ovl_i)
      |=> (state_q == ST_IDLE && !flag_q));

  // R6
  static_never_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && static_i) |=> (state_q != ST_OFF));

  // R8
  disable_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (state_q == ST_IDLE && !flag_q));

  // R9
  ss_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_done_i |=> !flag_q);
endmodule

// File: rtl/ocp_sequencer.sv
module ocp_sequencer
  import ocp_pkg::*;
#(
  parameter int T_OFF = 900,
  parameter int T_ON  = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic ss_done_i,
  input  logic static_mode_i,
  input  logic ovl_i,
  input  logic tick_i,
  output logic out_on_o,
  output logic ovl_flag_o
);
  ocp_state_e state;
  logic       clr, sel_off, done, flag;

  ocp_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .ss_done_i (ss_done_i),
    .static_i  (static_mode_i),
    .ovl_i     (ovl_i),
    .done_i    (done),
    .state_o   (state),
    .flag_o    (flag),
    .clr_o     (clr),
    .sel_off_o (sel_off)
  );

  ocp_win_timer #(.T_OFF(T_OFF), .T_ON(T_ON)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .sel_off_i (sel_off),
    .tick_i    (tick_i),
    .done_o    (done)
  );

  assign out_on_o   = enable_i && (state != ST_OFF);
  assign ovl_flag_o = flag;

  // R1
  flag_low_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !ovl_flag_o);

  // R8
  off_when_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !out_on_o);
endmodule

// File: tb/ocp_sequencer_tb_top.sv
module ocp_sequencer_tb_top;
  localparam int T_OFF = 9;
  localparam int T_ON  = 4;
  localparam int TDIV  = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic enable_i = 1'b0, ss_done_i = 1'b0, static_mode_i = 1'b0, ovl_i = 1'b0, tick_i = 1'b0;
  logic out_on_o, ovl_flag_o;

  int checks = 0, fails = 0;
  bit tick_en = 1'b1, fin = 1'b0;
  int tick_ph = 0;
  int off_ticks = 0, on_ticks = 0;

  int m_state = 0, m_cnt = 0;
  bit m_hit = 1'b0, m_flag = 1'b0;

  always #5 clk = ~clk;

  ocp_sequencer #(.T_OFF(T_OFF), .T_ON(T_ON)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .ss_done_i(ss_done_i),
    .static_mode_i(static_mode_i), .ovl_i(ovl_i), .tick_i(tick_i),
    .out_on_o(out_on_o), .ovl_flag_o(ovl_flag_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    tick_ph = (tick_ph + 1) % TDIV;
    tick_i  = tick_en && (tick_ph == 0);
  end

  // behavioural reference: 0 idle, 1 resting off, 2 retry
  always @(posedge clk) begin
    if (enable_i && ss_done_i && !static_mode_i) begin
      if (tick_i && !out_on_o) off_ticks++;
      if (tick_i && out_on_o && ovl_flag_o) on_ticks++;
    end
    if (!rst_ni || !enable_i || !ss_done_i) begin
      m_state = 0; m_cnt = 0; m_hit = 0; m_flag = 0;
    end else if (static_mode_i) begin
      m_state = 0; m_cnt = 0; m_hit = 0; m_flag = ovl_i;
    end else if (m_state == 0) begin
      m_hit = 0;
      if (ovl_i) begin m_state = 1; m_cnt = 0; m_flag = 1; end
      else m_flag = 0;
    end else if (m_state == 1) begin
      if (tick_i) begin
        if (m_cnt == T_OFF - 1) begin m_state = 2; m_cnt = 0; m_hit = 0; end
        else m_cnt++;
      end
    end else begin
      if (tick_i && m_cnt == T_ON - 1) begin
        m_state = (m_hit || ovl_i) ? 1 : 0;
        if (m_state == 0) m_flag = 0;
        m_cnt = 0; m_hit = 0;
      end else begin
        m_hit = m_hit || ovl_i;
        if (tick_i) m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !fin) begin
      chk(out_on_o == (enable_i && m_state != 1), "R3 model out_on", out_on_o, enable_i && m_state != 1);
      chk(ovl_flag_o == m_flag, "R4 model flag", ovl_flag_o, m_flag);
    end
  end

  task automatic drv();
    @(posedge clk); #2;
  endtask
  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask
  task automatic wait_out(input bit v, input string req);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (out_on_o == v) return;
    end
    chk(1'b0, req, out_on_o, v);
  endtask
  task automatic wait_flag_low(input string req);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!ovl_flag_o) return;
    end
    chk(1'b0, req, ovl_flag_o, 0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int off_seen;
    repeat (3) @(posedge clk);
    #2; rst_ni = 1'b1;
    @(negedge clk);
    chk(!out_on_o, "R8 off while disabled", out_on_o, 0);
    chk(!ovl_flag_o, "R1 flag after reset", ovl_flag_o, 0);
    drv(); enable_i = 1'b1;
    settle();
    chk(out_on_o, "R1 out follows enable", out_on_o, 1);
    drv(); ovl_i = 1'b1;
    repeat (5) @(negedge clk);
    chk(!ovl_flag_o, "R9 ignored before soft-start", ovl_flag_o, 0);
    chk(out_on_o, "R9 out kept on", out_on_o, 1);
    drv(); ovl_i = 1'b0; ss_done_i = 1'b1;
    repeat (10) @(negedge clk);

    // R2 / R3 / R4 with a persistent overload
    drv(); off_ticks = 0; ovl_i = 1'b1;
    settle();
    chk(!out_on_o, "R2 out off", out_on_o, 0);
    chk(ovl_flag_o, "R2 flag set", ovl_flag_o, 1);
    wait_out(1'b1, "R3 wait on");
    chk(off_ticks == T_OFF, "R3 rest ticks", off_ticks, T_OFF);
    on_ticks = 0;
    wait_out(1'b0, "R4 wait off");
    chk(on_ticks == T_ON, "R4 retry ticks", on_ticks, T_ON);
    chk(ovl_flag_o, "R4 flag held", ovl_flag_o, 1);
    off_ticks = 0;
    drv(); ovl_i = 1'b0;
    wait_out(1'b1, "R3 wait on 2");
    chk(off_ticks == T_OFF, "R3 rest ticks 2", off_ticks, T_OFF);
    on_ticks = 0;
    wait_flag_low("R5 wait flag");
    chk(on_ticks == T_ON, "R5 clean retry ticks", on_ticks, T_ON);
    chk(out_on_o, "R5 out stays on", out_on_o, 1);

    // R4: single-cycle pulses inside retry at several tick phases
    for (int ph = 0; ph < TDIV + 1; ph++) begin
      drv(); ovl_i = 1'b1;
      drv(); ovl_i = 1'b0;
      wait_out(1'b1, "R4 wait retry");
      repeat (ph + 3 * (T_ON - 1)) @(posedge clk);
      #2; ovl_i = 1'b1;
      drv(); ovl_i = 1'b0;
      wait_out(1'b0, "R4 pulse back off");
      chk(ovl_flag_o, "R4 pulse keeps flag", ovl_flag_o, 1);
      wait_flag_low("R5 recovery");
      chk(out_on_o, "R5 recovered on", out_on_o, 1);
    end

    // R10: no ticks, stays off
    drv(); tick_en = 1'b0; ovl_i = 1'b1;
    drv(); ovl_i = 1'b0;
    repeat (60) @(negedge clk);
    chk(!out_on_o, "R10 held off", out_on_o, 0);
    chk(ovl_flag_o, "R10 flag held", ovl_flag_o, 1);
    drv(); tick_en = 1'b1;
    wait_flag_low("R10 resume");

    // R6: clamp-only
    drv(); static_mode_i = 1'b1; ovl_i = 1'b1;
    settle();
    chk(ovl_flag_o, "R6 flag follows", ovl_flag_o, 1);
    off_seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (!out_on_o) off_seen++;
    end
    chk(off_seen == 0, "R6 never off", off_seen, 0);
    drv(); ovl_i = 1'b0;
    settle();
    chk(!ovl_flag_o, "R6 flag clears", ovl_flag_o, 0);

    // R7: mode changes
    drv(); ovl_i = 1'b1;
    settle();
    drv(); static_mode_i = 1'b0;
    settle();
    chk(!out_on_o, "R7 to hiccup cuts", out_on_o, 0);
    repeat (7) @(negedge clk);
    drv(); static_mode_i = 1'b1;
    settle();
    chk(out_on_o, "R7 to clamp restores", out_on_o, 1);
    chk(ovl_flag_o, "R7 flag follows ovl", ovl_flag_o, 1);
    drv(); ovl_i = 1'b0; static_mode_i = 1'b0;
    settle();
    drv(); off_ticks = 0; ovl_i = 1'b1;
    drv(); ovl_i = 1'b0;
    wait_out(1'b1, "R7 wait on");
    chk(off_ticks == T_OFF, "R7 full rest after clear", off_ticks, T_OFF);
    wait_flag_low("R7 recovery");

    // R8: disable mid-rest
    drv(); ovl_i = 1'b1;
    settle();
    chk(!out_on_o, "R8 in rest", out_on_o, 0);
    drv(); enable_i = 1'b0;
    settle();
    chk(!out_on_o, "R8 out off", out_on_o, 0);
    chk(!ovl_flag_o, "R8 flag cleared", ovl_flag_o, 0);
    drv(); enable_i = 1'b1; ovl_i = 1'b0;
    settle();
    chk(out_on_o, "R8 re-enabled on", out_on_o, 1);
    chk(!ovl_flag_o, "R8 re-enabled flag", ovl_flag_o, 0);

    fin = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule